// File: doc/BRIEF.md
# Interleaved Multi-Context SHA-1 Compression Engine

This block runs the SHA-1 compression function on up to five independent 512-bit blocks at once and shares a single 32-bit port among them. A block enters as sixteen 32-bit words with a valid/ready handshake. The first word of a block also carries a tag and a selector that picks either the standard initial chaining value or a caller-supplied 160-bit midstate. Each context starts its 80 rounds as soon as its first word is stored. For rounds 0 to 15 it uses the words as they arrive, and for later rounds it expands the schedule in a rolling 16-word window.

When a context finishes, its five-word digest goes out over the same port, together with the tag it was loaded with. Input and output never use the port at the same time. A block that has begun loading always finishes loading before any digest is sent. While one context streams in, the others are computing, so the port is the only shared bottleneck. Message padding and the chaining of multiple blocks are left to the caller. The caller can chain blocks by feeding a returned digest back in as a midstate.

Top module: `sha1_mctx_engine`

## Requirements
- R1: While reset is held and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: When `in_use_mid`=0 on a block's first word, the digest is SHA-1 compression from chaining value 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0. The rounds use Ch/5A827999 for rounds 0-19, parity/6ED9EBA1 for 20-39, Maj/8F1BBCDC for 40-59 and parity/CA62C1D6 for 60-79. Each working variable is added to its chaining word modulo 2^32. Word 0 of a block is the first word transferred. For the block "abc" padded, the digest is a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R3: When `in_use_mid`=1 on a block's first word, `in_mid` is the chaining value. H0 sits in bits [159:128] and H4 in bits [31:0]. This lets a digest fed back as a midstate yield the digest of a two-block message.
- R4: A digest appears as exactly five consecutive `out_valid` cycles carrying H0, H1, H2, H3, H4 in that order. `out_tag` is constant across the burst and equals the `in_tag` sampled with that block's first word. Each burst is followed by at least one cycle with `out_valid`=0.
- R5: `in_ready` is 0 in every cycle in which `out_valid` is 1.
- R6: Once the first word of a block is accepted, `in_ready` stays 1 and `out_valid` stays 0 until the sixteenth word of that block is accepted.
- R7: Five blocks can be in flight at once. At a block boundary with five contexts holding digests not yet sent, `in_ready` is 0.
- R8: When the port is idle and a block's sixteen words arrive in consecutive cycles, the first digest word is presented 82 clock cycles after the cycle in which the first word is accepted.
- R9: Idle cycles between the words of a block delay the rounds but do not change the digest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Engine accepts the input word this cycle |
| in_data | input | 32 | Message word, word 0 of the block first |
| in_use_mid | input | 1 | Chaining select on first word: 0 standard value, 1 `in_mid` |
| in_mid | input | 160 | Supplied chaining value, H0 in the top bits |
| in_tag | input | TAGW | Request tag, sampled with the first word |
| out_valid | output | 1 | Digest word present |
| out_data | output | 32 | Digest word, H0 first |
| out_tag | output | TAGW | Tag of the context producing the digest |

## Verification
The bench tries the block with a known-answer padded "abc" block, with all-zero, all-one, alternating, counting and random blocks, and with a second block chained through a midstate. The known answer separates a wrong round function or constant from a bench model error. The midstate pair shows whether `in_mid` is really the chaining value, because the same block under the standard value gives a different result. Five back-to-back blocks followed by a sixth block check the context limit and the matching of tags out of order. A slowly loaded block that overlaps another context's completion checks the half-duplex rule and shows that input gaps leave the digest unchanged.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  typedef logic [31:0]  word_t;
  typedef logic [159:0] chain_t;

  typedef enum logic [1:0] {SLOT_IDLE, SLOT_BUSY, SLOT_DONE} slot_st_t;

  localparam chain_t STD_IV = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                               32'h10325476, 32'hC3D2E1F0};

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // round function plus its constant, chosen by the round index
  function automatic word_t round_fk(input logic [6:0] t, input word_t b,
                                     input word_t c, input word_t d);
    if (t < 7'd20)      return ((b & c) | (~b & d)) + 32'h5A827999;
    else if (t < 7'd40) return (b ^ c ^ d) + 32'h6ED9EBA1;
    else if (t < 7'd60) return ((b & c) | (b & d) | (c & d)) + 32'h8F1BBCDC;
    else                return (b ^ c ^ d) + 32'hCA62C1D6;
  endfunction
endpackage

// File: rtl/sha1_ctx_slot.sv
module sha1_ctx_slot
  import sha1_pkg::*;
#(
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wr_en,
  input  word_t           wr_data,
  input  logic            use_mid,
  input  chain_t          mid,
  input  logic [TAGW-1:0] tag_in,
  input  logic            pop,
  input  logic [2:0]      rd_idx,
  output logic            idle,
  output logic            done,
  output word_t           rd_word,
  output logic [TAGW-1:0] tag_o
);
  localparam logic [6:0] LAST_ROUND = 7'd79;

  slot_st_t        st, st_n;
  logic [6:0]      t, t_n;
  logic [4:0]      wcnt, wcnt_n;
  word_t           a, b, c, d, e;
  chain_t          h;
  word_t           w [16];
  logic [TAGW-1:0] tag_q;

  logic       round_go;
  logic [3:0] i3, i8, i14, wr_ptr;
  word_t      wt, tmp;
  chain_t     chain_sel;

  assign chain_sel = use_mid ? mid : STD_IV;
  assign round_go  = (st == SLOT_BUSY) && ((t >= 7'd16) || ({2'b00, wcnt} > t));
  assign i3        = t[3:0] - 4'd3;
  assign i8        = t[3:0] - 4'd8;
  assign i14       = t[3:0] - 4'd14;
  assign wt        = (t < 7'd16) ? w[t[3:0]]
                   : rotl(w[i3] ^ w[i8] ^ w[i14] ^ w[t[3:0]], 1);
  assign tmp       = rotl(a, 5) + round_fk(t, b, c, d) + e + wt;
  assign wr_ptr    = start ? 4'd0 : wcnt[3:0];

  // control next state
  always_comb begin
    st_n   = st;
    t_n    = t;
    wcnt_n = wcnt;
    case (st)
      SLOT_IDLE: if (start) begin
        st_n   = SLOT_BUSY;
        t_n    = 7'd0;
        wcnt_n = 5'd1;
      end
      SLOT_BUSY: begin
        if (wr_en) wcnt_n = wcnt + 5'd1;
        if (round_go) begin
          t_n = t + 7'd1;
          if (t == LAST_ROUND) st_n = SLOT_DONE;
        end
      end
      SLOT_DONE: if (pop) st_n = SLOT_IDLE;
      default:   st_n = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SLOT_IDLE;
      t    <= 7'd0;
      wcnt <= 5'd0;
    end else begin
      st   <= st_n;
      t    <= t_n;
      wcnt <= wcnt_n;
    end
  end

  // datapath, no reset needed
  always_ff @(posedge clk) begin
    if (start) begin
      h     <= chain_sel;
      tag_q <= tag_in;
      {a, b, c, d, e} <= chain_sel;
    end else if (round_go) begin
      e <= d;
      d <= c;
      c <= rotl(b, 30);
      b <= a;
      a <= tmp;
    end
    if (wr_en) w[wr_ptr] <= wr_data;
    if (round_go && (t >= 7'd16)) w[t[3:0]] <= wt;
  end

  always_comb begin
    case (rd_idx)
      3'd0:    rd_word = h[159:128] + a;
      3'd1:    rd_word = h[127:96]  + b;
      3'd2:    rd_word = h[95:64]   + c;
      3'd3:    rd_word = h[63:32]   + d;
      default: rd_word = h[31:0]    + e;
    endcase
  end

  assign idle  = (st == SLOT_IDLE);
  assign done  = (st == SLOT_DONE);
  assign tag_o = tag_q;
endmodule

// File: rtl/sha1_port_ctl.sv
module sha1_port_ctl #(
  parameter int NCTX = 5,
  localparam int IW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [NCTX-1:0] idle_v,
  input  logic [NCTX-1:0] done_v,
  output logic            in_ready,
  output logic [NCTX-1:0] start_v,
  output logic [NCTX-1:0] wr_v,
  output logic [NCTX-1:0] pop_v,
  output logic            out_busy,
  output logic [IW-1:0]   out_slot,
  output logic [2:0]      out_idx
);
  localparam logic [NCTX-1:0] ONE = {{(NCTX-1){1'b0}}, 1'b1};

  logic          load_active, load_active_n;
  logic [IW-1:0] load_slot, load_slot_n;
  logic [3:0]    load_cnt, load_cnt_n;
  logic          out_busy_n;
  logic [IW-1:0] out_slot_n;
  logic [2:0]    out_idx_n;

  logic          any_idle, any_done, accept, out_go;
  logic [IW-1:0] first_idle, first_done, tgt;

  // lowest-index free and finished contexts
  always_comb begin
    any_idle   = 1'b0;
    any_done   = 1'b0;
    first_idle = '0;
    first_done = '0;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (idle_v[i]) begin any_idle = 1'b1; first_idle = IW'(i); end
      if (done_v[i]) begin any_done = 1'b1; first_done = IW'(i); end
    end
  end

  assign in_ready = load_active || (!out_busy && !any_done && any_idle);
  assign accept   = in_valid && in_ready;
  assign tgt      = load_active ? load_slot : first_idle;
  assign start_v  = (accept && !load_active) ? (ONE << first_idle) : '0;
  assign wr_v     = accept ? (ONE << tgt) : '0;
  assign out_go   = !load_active && !out_busy && any_done;
  assign pop_v    = (out_busy && out_idx == 3'd4) ? (ONE << out_slot) : '0;

  always_comb begin
    load_active_n = load_active;
    load_slot_n   = load_slot;
    load_cnt_n    = load_cnt;
    out_busy_n    = out_busy;
    out_slot_n    = out_slot;
    out_idx_n     = out_idx;
    if (accept) begin
      load_cnt_n    = load_cnt + 4'd1;
      load_active_n = (load_cnt != 4'd15);
      if (!load_active) load_slot_n = first_idle;
    end
    if (out_go) begin
      out_busy_n = 1'b1;
      out_slot_n = first_done;
      out_idx_n  = 3'd0;
    end else if (out_busy) begin
      out_idx_n  = out_idx + 3'd1;
      if (out_idx == 3'd4) out_busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_active <= 1'b0;
      load_slot   <= '0;
      load_cnt    <= 4'd0;
      out_busy    <= 1'b0;
      out_slot    <= '0;
      out_idx     <= 3'd0;
    end else begin
      load_active <= load_active_n;
      load_slot   <= load_slot_n;
      load_cnt    <= load_cnt_n;
      out_busy    <= out_busy_n;
      out_slot    <= out_slot_n;
      out_idx     <= out_idx_n;
    end
  end
endmodule

// File: rtl/sha1_mctx_engine.sv
module sha1_mctx_engine
  import sha1_pkg::*;
#(
  parameter int NCTX = 5,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_data,
  input  logic            in_use_mid,
  input  logic [159:0]    in_mid,
  input  logic [TAGW-1:0] in_tag,
  output logic            out_valid,
  output logic [31:0]     out_data,
  output logic [TAGW-1:0] out_tag
);
  localparam int IW = (NCTX > 1) ? $clog2(NCTX) : 1;

  logic [NCTX-1:0] idle_v, done_v, start_v, wr_v, pop_v;
  logic [IW-1:0]   out_slot;
  logic [2:0]      out_idx;
  logic            out_busy;
  word_t           rd_word [NCTX];
  logic [TAGW-1:0] slot_tag [NCTX];

  sha1_port_ctl #(.NCTX(NCTX)) u_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .idle_v(idle_v), .done_v(done_v), .in_ready(in_ready),
    .start_v(start_v), .wr_v(wr_v), .pop_v(pop_v),
    .out_busy(out_busy), .out_slot(out_slot), .out_idx(out_idx)
  );

  for (genvar g = 0; g < NCTX; g++) begin : g_slot
    sha1_ctx_slot #(.TAGW(TAGW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .start(start_v[g]), .wr_en(wr_v[g]), .wr_data(in_data),
      .use_mid(in_use_mid), .mid(in_mid), .tag_in(in_tag),
      .pop(pop_v[g]), .rd_idx(out_idx),
      .idle(idle_v[g]), .done(done_v[g]),
      .rd_word(rd_word[g]), .tag_o(slot_tag[g])
    );
  end

  always_comb begin
    out_data = '0;
    out_tag  = '0;
    for (int i = 0; i < NCTX; i++) begin
      if (out_slot == IW'(i)) begin
        out_data = rd_word[i];
        out_tag  = slot_tag[i];
      end
    end
  end

  assign out_valid = out_busy;
endmodule

// File: rtl/sha1_mctx_checker.sv
module sha1_mctx_checker #(
  parameter int TAGW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic [TAGW-1:0] out_tag
);
  logic [3:0] lcnt;
  logic [2:0] ocnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt <= 4'd0;
      ocnt <= 3'd0;
    end else begin
      if (in_valid && in_ready) lcnt <= lcnt + 4'd1;
      if (out_valid) ocnt <= (ocnt == 3'd4) ? 3'd0 : ocnt + 3'd1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!out_valid);
  end

  assert_port_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_no_out_midload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt != 4'd0) |-> !out_valid);

  assert_ready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt != 4'd0) |-> in_ready);

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ocnt != 3'd4) |=> out_valid);

  assert_burst_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ocnt == 3'd4) |=> !out_valid);

  assert_tag_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ocnt != 3'd0) |-> $stable(out_tag));
endmodule

bind sha1_mctx_engine sha1_mctx_checker #(.TAGW(TAGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_tag(out_tag)
);

// File: tb/sha1_mctx_engine_bench.sv
module sha1_mctx_engine_bench;
  localparam int TAGW = 4;
  localparam logic [159:0] IV0 = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                  32'h10325476, 32'hC3D2E1F0};

  logic            clk, rst_n, in_valid, in_ready, in_use_mid, out_valid;
  logic [31:0]     in_data, out_data;
  logic [159:0]    in_mid;
  logic [TAGW-1:0] in_tag, out_tag;

  sha1_mctx_engine #(.NCTX(5), .TAGW(TAGW)) u_sha1_mctx_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_use_mid(in_use_mid), .in_mid(in_mid),
    .in_tag(in_tag), .out_valid(out_valid), .out_data(out_data),
    .out_tag(out_tag)
  );

  int checks = 0, failures = 0, cyc = 0, ldcnt = 0, ocnt = 0, npend = 0;
  int lat_c0 = 0;
  bit lat_want = 0, lat_arm = 0;
  logic [3:0]   lat_tag, cur_tag;
  logic [159:0] exp_d [16];
  bit           pend [16];

  initial clk = 0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [159:0] act,
                     input logic [159:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [159:0] ref_sha1(input logic [159:0] hin,
                                            input logic [511:0] blk);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, tmp, x;
    for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
    for (int i = 16; i < 80; i++) begin
      x = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
      w[i] = {x[30:0], x[31]};
    end
    {a, b, c, d, e} = hin;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      tmp = {a[26:0], a[31:27]} + f + e + k + w[i];
      e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = tmp;
    end
    return {hin[159:128] + a, hin[127:96] + b, hin[95:64] + c,
            hin[63:32] + d, hin[31:0] + e};
  endfunction

  task automatic expect_blk(input logic [3:0] tag, input logic [159:0] d);
    exp_d[tag] = d;
    pend[tag]  = 1;
    npend++;
  endtask

  task automatic send_block(input logic [3:0] tag, input bit um,
                            input logic [159:0] mid, input logic [511:0] blk,
                            input int gap);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = blk[511 - 32*k -: 32];
      in_tag = tag; in_use_mid = um; in_mid = mid;
      while (!in_ready) @(negedge clk);
      if (k == 0 && lat_want) begin lat_c0 = cyc; lat_tag = tag; lat_arm = 1; lat_want = 0; end
      @(posedge clk);
      ldcnt = (ldcnt + 1) % 16;
      if (gap > 0) begin
        @(negedge clk); in_valid = 0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  // per-clock monitor against the bench's own expectations
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) chk(!in_ready, "R5 in_ready during output", 160'(in_ready), 0);
      if (ldcnt != 0) begin
        chk(!out_valid, "R6 output during block load", 160'(out_valid), 0);
        chk(in_ready, "R6 in_ready dropped mid-block", 160'(in_ready), 1);
      end
      if (ocnt != 0 && !out_valid) chk(0, "R4 digest burst broken", 0, 1);
      if (out_valid) begin
        if (ocnt == 0) begin
          cur_tag = out_tag;
          chk(pend[cur_tag], "R4 unexpected tag", 160'(out_tag), 0);
          if (lat_arm && out_tag == lat_tag) begin
            chk(cyc == lat_c0 + 82, "R8 latency", 160'(cyc - lat_c0), 82);
            lat_arm = 0;
          end
        end else begin
          chk(out_tag == cur_tag, "R4 tag changed in burst", 160'(out_tag), 160'(cur_tag));
        end
        chk(out_data == exp_d[cur_tag][159 - 32*ocnt -: 32], "R2/R3/R9 digest word",
            160'(out_data), 160'(exp_d[cur_tag][159 - 32*ocnt -: 32]));
        ocnt++;
        if (ocnt == 5) begin
          ocnt = 0;
          if (pend[cur_tag]) begin pend[cur_tag] = 0; npend--; end
        end
      end
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  task automatic drain;
    while (npend != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [511:0] abc, b1, b2, bs [6];
    logic [159:0] mid;
    for (int i = 0; i < 16; i++) pend[i] = 0;
    rst_n = 0; in_valid = 0; in_data = 0; in_use_mid = 0; in_mid = 0; in_tag = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid in reset", 160'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R1 in_ready after reset", 160'(in_ready), 1);
    chk(out_valid == 0, "R1 out_valid after reset", 160'(out_valid), 0);

    // R2 known answer and R8 latency
    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0]    = 32'h00000018;
    expect_blk(4'd3, 160'ha9993e364706816aba3e25717850c26c9cd0d89d);
    lat_want = 1;
    send_block(4'd3, 0, '0, abc, 0);
    drain();

    // R3 midstate chaining versus standard value on the same block
    b1 = {16{32'h0badf00d}} ^ {$urandom, $urandom, $urandom, $urandom,
          $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
          $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    b2 = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
          $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
          $urandom, $urandom, $urandom, $urandom};
    mid = ref_sha1(IV0, b1);
    expect_blk(4'd1, ref_sha1(mid, b2));
    send_block(4'd1, 1, mid, b2, 0);
    expect_blk(4'd2, ref_sha1(IV0, b2));
    send_block(4'd2, 0, mid, b2, 0);
    drain();

    // R7 five contexts in flight, then a sixth block waits
    bs[0] = '0;
    bs[1] = '1;
    bs[2] = {16{32'hAAAA5555}};
    for (int i = 0; i < 16; i++) bs[3][511 - 32*i -: 32] = 32'(i);
    bs[4] = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
             $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
             $urandom, $urandom, $urandom, $urandom};
    bs[5] = ~bs[4];
    for (int i = 0; i < 5; i++) begin
      expect_blk(4'(4 + i), ref_sha1(IV0, bs[i]));
      send_block(4'(4 + i), 0, '0, bs[i], 0);
    end
    chk(in_ready == 0, "R7 in_ready with five contexts busy", 160'(in_ready), 0);
    expect_blk(4'd9, ref_sha1(IV0, bs[5]));
    send_block(4'd9, 0, '0, bs[5], 0);
    drain();

    // R6/R9 slow load overlapping another context's completion
    expect_blk(4'd10, ref_sha1(IV0, bs[4]));
    send_block(4'd10, 0, '0, bs[4], 0);
    repeat (60) @(negedge clk);
    expect_blk(4'd11, ref_sha1(mid, bs[3]));
    send_block(4'd11, 1, mid, bs[3], 3);
    drain();

    finish_run();
  end
endmodule